// File: doc/BRIEF.md
# Strap-Selected Dual-Mode Host Register Port

This block gives a host processor access to a small bank of byte-wide registers over one shared set of pins. The pins work in one of two protocols. As a multiplexed parallel bus, a strobe captures either an address byte or a data byte, and a select line says which. As a three-wire serial port, a chip-enable frames a transfer, the strobe pin acts as the bit clock, and bus bit 1 and bus bit 0 carry serial data in and out. The protocol is fixed by strap levels on bus bits 6:4. The block takes them while reset is held low and keeps them from the moment reset is released.

All host inputs pass through a two-flop synchronizer into the core clock domain. Strobe edges are detected there. One controller state machine serves both protocols. Its states are:

- `S_BOOT`: the single cycle after reset. It leaves to `S_PAR_IDLE` or `S_SER_IDLE` according to the strap.
- `S_PAR_IDLE`: handles address strobes and write strobes. A data strobe with the read flag set moves it to `S_PAR_READ`.
- `S_PAR_READ`: drives the read byte while the strobe is high. The strobe falling edge returns it to `S_PAR_IDLE`.
- `S_SER_IDLE`: waits for chip-enable. Chip-enable high moves it to `S_SER_ADDR`.
- `S_SER_ADDR`: collects 8 address bits. The eighth rising clock edge moves it to `S_SER_DATA`.
- `S_SER_DATA`: moves 8 data bits. The eighth rising clock edge moves it to `S_SER_HOLD`.
- `S_SER_HOLD`: ignores further clocks.

Chip-enable low returns any serial state to `S_SER_IDLE`.

A core-side event pulse raises a pending interrupt. The pending interrupt is shown on an active-low request that only ever pulls low or releases. Reading the status register acknowledges it.

Top module: `hif_dual_port`

## Requirements
- R1: The mode is taken from bus bits 6:4 as they stand when reset is released and does not change until the next reset. Bit 6 high selects serial mode whatever bits 5:4 are. The pattern 0,1,0 selects parallel mode.
- R2: A strap with bit 6 low and bits 5:4 other than 1,0 selects parallel mode and sets status bit 1. Every other strap leaves status bit 1 clear.
- R3: In parallel mode, a strobe with select low takes bus bits 6:0 as the register address and bus bit 7 as the read flag (1 = read). A later address strobe replaces an earlier one.
- R4: In parallel mode, a strobe with select high and the read flag clear writes the bus byte to the addressed register, then advances the address by one, wrapping from 127 to 0. All registers read 0 after reset.
- R5: In parallel mode with the read flag set, while a select-high strobe is high the block enables all 8 bus outputs and drives the addressed byte. At the strobe fall it releases the bus and advances the address.
- R6: In serial mode with chip-enable high, bits are sampled from bus bit 1 on each rising clock, LSB first. The first 8 bits form the address byte, with bit 7 as the read flag (1 = read). For a write, the next 8 bits are stored in the addressed register.
- R7: In a serial read, bus bit 0 is the only enabled output, and only during the data phase. Each data bit appears LSB first after a falling clock edge. Clocks after the sixteenth are ignored until chip-enable goes low. Chip-enable low before the sixteenth bit abandons the frame without a write.
- R8: Address 127 is the status register. Bit 0 is interrupt pending, bit 1 is strap error and bit 2 is serial mode; the other bits read 0. Writes to it are ignored.
- R9: An event pulse sets the pending interrupt, and the request output pulls low while it is pending. A completed read of the status register clears it. An event in the same cycle as the clear wins.
- R10: In serial mode, strobe edges while chip-enable is low change no register and enable no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low system reset; its release fixes the mode |
| host_stb | input | 1 | Parallel strobe, or serial bit clock |
| host_sel | input | 1 | Parallel address/data select (low = address), or serial chip-enable (high = active) |
| host_bus_in | input | 8 | Bus input levels; bits 6:4 are the strap, bit 1 is serial data in |
| host_bus_out | output | 8 | Bus output values; bit 0 is serial data out |
| host_bus_oe | output | 8 | Per-bit output enable for the bus |
| core_evt | input | 1 | Single-cycle interrupt event from the core |
| irq_pull_low | output | 1 | High pulls the active-low request line low; low releases it |

## Verification
The assertions assume two things about the host. First, the strap levels stay steady over the last clock cycles of reset. Second, the select line and the bus byte settle before a strobe edge and stay put until the synchronized edge has been seen. The bench meets both. It sets the strap several cycles before reset release. It changes the select and bus two cycles before each strobe edge. It holds every strobe level for six core cycles, which is longer than the synchronizer and edge-detect latency. The serial host model changes data only while the clock is low and samples the output just before each rising edge.

// File: rtl/hif_pkg.sv
package hif_pkg;

    // Controller states shared by both host protocols
    typedef enum logic [2:0] {
        S_BOOT,
        S_PAR_IDLE,
        S_PAR_READ,
        S_SER_IDLE,
        S_SER_ADDR,
        S_SER_DATA,
        S_SER_HOLD
    } hif_state_e;

    // Pin roles that the protocol fixes
    localparam int STRAP_MODE_BIT = 6;  // high: serial
    localparam int STRAP_LO_BIT   = 4;  // low end of the strap field
    localparam int SER_DIN_BIT    = 1;
    localparam int SER_DOUT_BIT   = 0;

    // Status register bit positions
    localparam int ST_PEND_BIT = 0;
    localparam int ST_ERR_BIT  = 1;
    localparam int ST_SER_BIT  = 2;

endpackage

// File: rtl/hif_sync.sv
module hif_sync #(
    parameter int W = 10
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] meta;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta <= '0;
            q    <= '0;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end

endmodule

// File: rtl/hif_regfile.sv
module hif_regfile #(
    parameter int DW = 8,
    parameter int AW = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);

    localparam int NWORDS = 1 << AW;

    logic [DW-1:0] word_q [NWORDS];

    for (genvar g = 0; g < NWORDS; g++) begin : g_word
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                word_q[g] <= '0;
            else if (we && (waddr == AW'(g)))
                word_q[g] <= wdata;
        end
    end

    assign rdata = word_q[raddr];

endmodule

// File: rtl/hif_ctrl.sv
module hif_ctrl
    import hif_pkg::*;
#(
    parameter int DW = 8,
    parameter int AW = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          strap_ser,
    input  logic          strap_err,
    input  logic          stb_s,
    input  logic          sel_s,
    input  logic [DW-1:0] bus_s,
    input  logic          evt,
    input  logic [DW-1:0] reg_rdata,
    output logic          reg_we,
    output logic [AW-1:0] reg_addr,
    output logic [DW-1:0] reg_wdata,
    output logic [DW-1:0] bus_out,
    output logic [DW-1:0] bus_oe,
    output logic          irq_low
);

    localparam int            BCW    = $clog2(DW);
    localparam logic [BCW-1:0] LAST  = BCW'(DW - 1);
    localparam logic [AW-1:0] STAT_A = '1;

    hif_state_e     state, nxt;
    logic [AW-1:0]  addr;
    logic           rd_flag;
    logic [DW-1:0]  sh;
    logic [DW-1:0]  sh_next;
    logic [BCW-1:0] cnt, fcnt;
    logic           dout;
    logic           pending;
    logic           stb_d;
    logic           stb_rise, stb_fall;
    logic [DW-1:0]  status;
    logic [DW-1:0]  rd_val;
    logic           par_wr, ser_wr, ser_last_rise, stat_rd_done;

    assign stb_rise = stb_s & ~stb_d;
    assign stb_fall = ~stb_s & stb_d;
    assign sh_next  = {bus_s[SER_DIN_BIT], sh[DW-1:1]};

    always_comb begin
        status              = '0;
        status[ST_PEND_BIT] = pending;
        status[ST_ERR_BIT]  = strap_err;
        status[ST_SER_BIT]  = strap_ser;
    end

    assign rd_val   = (addr == STAT_A) ? status : reg_rdata;
    assign reg_addr = addr;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_BOOT;
        else        state <= nxt;
    end

    // Next-state logic
    always_comb begin
        nxt = state;
        unique case (state)
            S_BOOT:     nxt = strap_ser ? S_SER_IDLE : S_PAR_IDLE;
            S_PAR_IDLE: if (stb_rise && sel_s && rd_flag) nxt = S_PAR_READ;
            S_PAR_READ: if (stb_fall) nxt = S_PAR_IDLE;
            S_SER_IDLE: if (sel_s) nxt = S_SER_ADDR;
            S_SER_ADDR: begin
                if (!sel_s)                        nxt = S_SER_IDLE;
                else if (stb_rise && cnt == LAST)  nxt = S_SER_DATA;
            end
            S_SER_DATA: begin
                if (!sel_s)                        nxt = S_SER_IDLE;
                else if (stb_rise && cnt == LAST)  nxt = S_SER_HOLD;
            end
            S_SER_HOLD: if (!sel_s) nxt = S_SER_IDLE;
            default:    nxt = S_BOOT;
        endcase
    end

    // Outputs and register-file strobes
    always_comb begin
        ser_last_rise = (state == S_SER_DATA) && sel_s && stb_rise && (cnt == LAST);
        par_wr        = (state == S_PAR_IDLE) && stb_rise && sel_s && !rd_flag;
        ser_wr        = ser_last_rise && !rd_flag;
        reg_we        = (par_wr || ser_wr) && (addr != STAT_A);
        reg_wdata     = par_wr ? bus_s : sh_next;
        stat_rd_done  = (addr == STAT_A) && rd_flag &&
                        (((state == S_PAR_READ) && stb_fall) || ser_last_rise);
        bus_out = '0;
        bus_oe  = '0;
        if (state == S_PAR_READ) begin
            bus_oe  = '1;
            bus_out = rd_val;
        end
        if ((state == S_SER_DATA) && rd_flag && sel_s) begin
            bus_oe[SER_DOUT_BIT]  = 1'b1;
            bus_out[SER_DOUT_BIT] = dout;
        end
        irq_low = pending;
    end

    // Datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr    <= '0;
            rd_flag <= 1'b0;
            sh      <= '0;
            cnt     <= '0;
            fcnt    <= '0;
            dout    <= 1'b0;
            pending <= 1'b0;
            stb_d   <= 1'b0;
        end else begin
            stb_d <= stb_s;
            if (evt)               pending <= 1'b1;
            else if (stat_rd_done) pending <= 1'b0;
            unique case (state)
                S_PAR_IDLE: begin
                    if (stb_rise) begin
                        if (!sel_s) begin
                            addr    <= bus_s[AW-1:0];
                            rd_flag <= bus_s[DW-1];
                        end else if (!rd_flag) begin
                            addr <= addr + AW'(1);
                        end
                    end
                end
                S_PAR_READ: if (stb_fall) addr <= addr + AW'(1);
                S_SER_IDLE: begin
                    cnt  <= '0;
                    fcnt <= '0;
                    dout <= 1'b0;
                end
                S_SER_ADDR: begin
                    if (sel_s && stb_rise) begin
                        sh  <= sh_next;
                        cnt <= (cnt == LAST) ? '0 : cnt + BCW'(1);
                        if (cnt == LAST) begin
                            addr    <= sh_next[AW-1:0];
                            rd_flag <= sh_next[DW-1];
                        end
                    end
                end
                S_SER_DATA: begin
                    if (sel_s) begin
                        if (stb_rise) begin
                            sh  <= sh_next;
                            cnt <= (cnt == LAST) ? '0 : cnt + BCW'(1);
                        end
                        if (stb_fall && rd_flag) begin
                            dout <= rd_val[fcnt];
                            fcnt <= fcnt + BCW'(1);
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    // R9: an event always leaves the interrupt pending
    p_evt_sets_irq_r9: assert property (@(posedge clk) disable iff (!rst_n)
        evt |=> irq_low);

    // R9: a completed status read without a competing event releases the request
    p_stat_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_rd_done && !evt) |=> !irq_low);

    // R5: a parallel read never drives a partial byte
    p_par_oe_full_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!strap_ser && (bus_oe != '0)) |-> (bus_oe == '1));

    // R7: serial mode only ever enables the data-out bit
    p_ser_oe_bit0_r7: assert property (@(posedge clk) disable iff (!rst_n)
        strap_ser |-> (bus_oe[DW-1:1] == '0));

    // R10: no output is enabled while chip-enable is low in serial mode
    p_ser_oe_needs_ce_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (strap_ser && !sel_s) |-> (bus_oe == '0));

    // R7: data out moves only after a falling clock edge
    p_dout_on_fall_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == S_SER_DATA) && !stb_fall) |=> $stable(dout));

    // R1: the mode stays put after reset release
    p_mode_stable_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (state != S_BOOT) |-> $stable(strap_ser));

endmodule

// File: rtl/hif_dual_port.sv
module hif_dual_port
    import hif_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_stb,
    input  logic              host_sel,
    input  logic [DATA_W-1:0] host_bus_in,
    output logic [DATA_W-1:0] host_bus_out,
    output logic [DATA_W-1:0] host_bus_oe,
    input  logic              core_evt,
    output logic              irq_pull_low
);

    localparam int SYNC_W  = DATA_W + 2;
    localparam int STRAP_W = STRAP_MODE_BIT - STRAP_LO_BIT + 1;

    logic [STRAP_W-1:0] strap_q;
    logic               strap_ser, strap_err;
    logic [SYNC_W-1:0]  sync_q;
    logic               stb_s, sel_s;
    logic [DATA_W-1:0]  bus_s;
    logic               reg_we;
    logic [ADDR_W-1:0]  reg_addr;
    logic [DATA_W-1:0]  reg_wdata, reg_rdata;

    // Strap levels follow the bus while reset is low and freeze at release
    always_ff @(posedge clk) begin
        if (!rst_n) strap_q <= host_bus_in[STRAP_MODE_BIT:STRAP_LO_BIT];
    end

    assign strap_ser = strap_q[STRAP_W-1];
    assign strap_err = !strap_q[STRAP_W-1] && (strap_q[STRAP_W-2:0] != 2'b10);

    hif_sync #(.W(SYNC_W)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({host_stb, host_sel, host_bus_in}),
        .q     (sync_q)
    );

    assign {stb_s, sel_s, bus_s} = sync_q;

    hif_regfile #(.DW(DATA_W), .AW(ADDR_W)) u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (reg_we),
        .waddr (reg_addr),
        .wdata (reg_wdata),
        .raddr (reg_addr),
        .rdata (reg_rdata)
    );

    hif_ctrl #(.DW(DATA_W), .AW(ADDR_W)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .strap_ser (strap_ser),
        .strap_err (strap_err),
        .stb_s     (stb_s),
        .sel_s     (sel_s),
        .bus_s     (bus_s),
        .evt       (core_evt),
        .reg_rdata (reg_rdata),
        .reg_we    (reg_we),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .bus_out   (host_bus_out),
        .bus_oe    (host_bus_oe),
        .irq_low   (irq_pull_low)
    );

endmodule

// File: tb/sim_hif_dual_port.sv
module sim_hif_dual_port;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       stb = 1'b0;
    logic       sel = 1'b0;
    logic [7:0] bus = 8'h00;
    logic       evt = 1'b0;
    logic [7:0] bus_out, bus_oe;
    logic       irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;  // 250 MHz

    hif_dual_port u0 (
        .clk          (clk),
        .rst_n        (rst_n),
        .host_stb     (stb),
        .host_sel     (sel),
        .host_bus_in  (bus),
        .host_bus_out (bus_out),
        .host_bus_oe  (bus_oe),
        .core_evt     (evt),
        .irq_pull_low (irq)
    );

    task automatic hold(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] pat_p(input int a);
        return 8'((a * 37) + 5);
    endfunction

    function automatic logic [7:0] pat_s(input int a);
        return 8'((a * 53) + 9);
    endfunction

    task automatic do_reset(input logic [2:0] strap);
        rst_n = 1'b0;
        stb = 1'b0;
        sel = 1'b0;
        evt = 1'b0;
        bus = {1'b0, strap, 4'b0000};
        hold(5);
        rst_n = 1'b1;
        hold(2);
        bus = 8'h00;
        hold(4);
    endtask

    task automatic par_addr(input logic [7:0] a);
        sel = 1'b0;
        bus = a;
        hold(2);
        stb = 1'b1;
        hold(6);
        stb = 1'b0;
        hold(6);
    endtask

    task automatic par_write(input logic [7:0] d);
        sel = 1'b1;
        bus = d;
        hold(2);
        stb = 1'b1;
        hold(6);
        stb = 1'b0;
        hold(6);
    endtask

    task automatic par_read(output logic [7:0] d, output logic [7:0] oe_hi, output logic [7:0] oe_lo);
        sel = 1'b1;
        bus = 8'h00;
        hold(2);
        stb = 1'b1;
        hold(6);
        d = bus_out;
        oe_hi = bus_oe;
        stb = 1'b0;
        hold(6);
        oe_lo = bus_oe;
    endtask

    // Serial frame: nbits clocks; bits past 16 are sent as ones
    task automatic ser_xfer(input logic [7:0] abyte, input logic [7:0] wd, input int nbits,
                            output logic [7:0] rd, output logic oe_ok);
        logic [15:0] frame;
        frame = {wd, abyte};
        rd = 8'h00;
        oe_ok = 1'b1;
        sel = 1'b1;
        hold(6);
        for (int i = 0; i < nbits; i++) begin
            stb = 1'b0;
            bus[1] = (i < 16) ? frame[i] : 1'b1;
            hold(6);
            if (i >= 8 && i < 16) begin
                rd[i-8] = bus_out[0];
                if (bus_oe !== (abyte[7] ? 8'h01 : 8'h00)) oe_ok = 1'b0;
            end else if (bus_oe !== 8'h00) begin
                oe_ok = 1'b0;
            end
            stb = 1'b1;
            hold(6);
        end
        stb = 1'b0;
        hold(6);
        if (bus_oe !== 8'h00) oe_ok = 1'b0;
        sel = 1'b0;
        bus = 8'h00;
        hold(6);
    endtask

    task automatic status_read(input logic ser, output logic [7:0] st);
        logic [7:0] h, l;
        logic ok;
        if (ser) ser_xfer(8'hFF, 8'h00, 16, st, ok);
        else begin
            par_addr(8'hFF);
            par_read(st, h, l);
        end
    endtask

    task automatic pulse_evt();
        evt = 1'b1;
        hold(1);
        evt = 1'b0;
        hold(3);
    endtask

    initial begin
        logic [7:0] d, h, l, st;
        logic ok;
        logic ser, err;

        // Strap sweep: every pattern on bits 6:4
        for (int s = 0; s < 8; s++) begin
            do_reset(3'(s));
            ser = s[2];
            err = !s[2] && (s[1:0] != 2'b10);
            chk("R1 reset oe", 32'(bus_oe), 32'h0);
            chk("R9 reset irq", 32'(irq), 32'h0);
            status_read(ser, st);
            chk("R1 mode bit", 32'(st[2]), 32'(ser));
            chk("R2 strap error bit", 32'(st[1]), 32'(err));
            chk("R8 status unused bits", 32'({st[7:3], st[0]}), 32'h0);
        end

        // Parallel session
        do_reset(3'b010);
        par_addr(8'h85);
        par_read(d, h, l);
        chk("R4 reset value", 32'(d), 32'h0);
        chk("R5 oe during read", 32'(h), 32'hFF);
        chk("R5 oe after read", 32'(l), 32'h0);

        par_addr(8'h00);
        for (int a = 0; a < 127; a++) par_write(pat_p(a));
        par_addr(8'h80);
        for (int a = 0; a < 127; a++) begin
            par_read(d, h, l);
            chk("R4 R5 write/read sweep", 32'(d), 32'(pat_p(a)));
        end

        par_addr(8'h00 | 8'd126);
        par_write(8'hA1);
        par_write(8'hB2);
        par_write(8'hC3);
        par_addr(8'h80 | 8'd126);
        par_read(d, h, l);
        chk("R4 write before wrap", 32'(d), 32'hA1);
        par_read(d, h, l);
        chk("R8 status write ignored", 32'(d), 32'h00);
        par_read(d, h, l);
        chk("R4 address wrap to 0", 32'(d), 32'hC3);

        par_addr(8'h80 | 8'd10);
        par_addr(8'h80 | 8'd20);
        par_read(d, h, l);
        chk("R3 later address wins", 32'(d), 32'(pat_p(20)));

        pulse_evt();
        chk("R9 irq after event", 32'(irq), 32'h1);
        status_read(1'b0, st);
        chk("R9 pending bit", 32'(st), 32'h01);
        chk("R9 irq released after read", 32'(irq), 32'h0);
        status_read(1'b0, st);
        chk("R9 pending cleared", 32'(st), 32'h00);

        // Serial session
        do_reset(3'b100);
        for (int a = 0; a < 127; a++) ser_xfer({1'b0, 7'(a)}, pat_s(a), 16, d, ok);
        for (int a = 0; a < 127; a++) begin
            ser_xfer({1'b1, 7'(a)}, 8'h00, 16, d, ok);
            chk("R6 R7 serial sweep", 32'(d), 32'(pat_s(a)));
            chk("R7 serial oe", 32'(ok), 32'h1);
        end

        ser_xfer(8'h03, 8'h5A, 21, d, ok);
        ser_xfer(8'h83, 8'h00, 16, d, ok);
        chk("R7 extra clocks ignored", 32'(d), 32'h5A);
        ser_xfer(8'h03, 8'hFF, 12, d, ok);
        ser_xfer(8'h83, 8'h00, 16, d, ok);
        chk("R7 abandoned frame", 32'(d), 32'h5A);

        ok = 1'b1;
        sel = 1'b0;
        for (int i = 0; i < 20; i++) begin
            stb = 1'b0;
            bus[1] = i[0];
            hold(6);
            if (bus_oe !== 8'h00) ok = 1'b0;
            stb = 1'b1;
            hold(6);
            if (bus_oe !== 8'h00) ok = 1'b0;
        end
        stb = 1'b0;
        bus = 8'h00;
        hold(6);
        chk("R10 no oe with enable low", 32'(ok), 32'h1);
        ser_xfer(8'h83, 8'h00, 16, d, ok);
        chk("R10 register untouched", 32'(d), 32'h5A);

        ser_xfer(8'h7F, 8'hFF, 16, d, ok);
        pulse_evt();
        chk("R9 serial irq", 32'(irq), 32'h1);
        status_read(1'b1, st);
        chk("R8 R9 serial status", 32'(st), 32'h05);
        chk("R9 serial irq released", 32'(irq), 32'h0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule